// File: doc/BRIEF.md
# Three-Lane Shift-Register Random Word Generator

This block produces a stream of 32-bit pseudo-random words from three independent 32-bit shift-register recurrences. Each recurrence mixes its word with a shifted copy of itself, clears a few low bits, shifts the result up, and folds the feedback bits back in. It uses no multiplier, so a fresh word is available every clock cycle in which the generator is told to step. The published word is the exclusive-OR of the three lanes, taken after they have stepped.

The three lane words are loaded together through a seed port. A lane whose seed is too small would fall into a degenerate short cycle. Any such seed is replaced by the default value 12345, so software does not have to screen its seeds. Reset puts 12345 into all three lanes. A consumer raises the step input whenever it wants new words and reads the output once the valid flag is up.

Top module: `tri_taus_gen`

## Requirements
- R1: After a synchronous reset (`rst` high at a rising edge) all three lanes hold 12345, `rand_out` is 0 and `rand_valid` is 0.
- R2: Lane A (seeded from `seed_a`) steps as: fb = ((a << 13) ^ a) >> 19; next a = ((a & 32'hFFFF_FFFE) << 12) ^ fb.
- R3: Lane B (seeded from `seed_b`) steps as: fb = ((b << 2) ^ b) >> 25; next b = ((b & 32'hFFFF_FFF8) << 4) ^ fb.
- R4: Lane C (seeded from `seed_c`) steps as: fb = ((c << 3) ^ c) >> 11; next c = ((c & 32'hFFFF_FFF0) << 17) ^ fb.
- R5: After a step, `rand_out` equals the XOR of the three lanes' new values, so it is computed from the updated state.
- R6: While `advance` stays high, one new word is produced on every clock edge, with no idle cycles.
- R7: While `advance` and `seed_load` are both low, the lanes, `rand_out` and `rand_valid` keep their values.
- R8: `rand_valid` goes to 1 one cycle after an edge at which `advance` is high and `seed_load` is low. The output register and the flag are loaded at that same edge.
- R9: At a seed load, lane A takes `seed_a` if it is at least 2, lane B takes `seed_b` if it is at least 8, and lane C takes `seed_c` if it is at least 16. Each lane below its minimum takes 12345 instead.
- R10: `seed_load` takes priority over `advance`. A load edge does not step the lanes, and it clears `rand_out` to 0 and `rand_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| seed_load | input | 1 | Load strobe for the three seed words |
| seed_a | input | 32 | Seed for lane A |
| seed_b | input | 32 | Seed for lane B |
| seed_c | input | 32 | Seed for lane C |
| advance | input | 1 | Step enable: one new word per edge while high |
| rand_out | output | 32 | Generated word |
| rand_valid | output | 1 | High once a word has been generated since the last reset or load |

## Verification
The assertions assume that `rst`, `seed_load` and `advance` are clean synchronous levels. They also assume that the seed words are stable at the edge where `seed_load` is sampled, because the guard checks compare the loaded lane against the value the seed port held at that edge. The stimulus changes every input only on the falling clock edge. It holds the seeds for the whole load cycle. It covers seeds on both sides of each lane minimum, and it deliberately raises the load strobe and the step input together to exercise the priority rule. The lane recurrences are checked through the output alone. Two seed sets that differ in a single lane are applied, and the difference between the two resulting words isolates that lane's step.

// File: rtl/tri_taus_pkg.sv
package tri_taus_pkg;
  localparam int unsigned W     = 32;
  localparam int unsigned NCOMP = 3;

  typedef logic [W-1:0] word_t;

  localparam word_t DEFAULT_SEED = 32'd12345;

  // Per-lane constants: left shift, feedback right shift, result shift, seed floor
  localparam int unsigned LSH_TAB   [NCOMP] = '{13, 2, 3};
  localparam int unsigned RSH_TAB   [NCOMP] = '{19, 25, 11};
  localparam int unsigned FSH_TAB   [NCOMP] = '{12, 4, 17};
  localparam int unsigned FLOOR_TAB [NCOMP] = '{2, 8, 16};

  // One step of a shift-register recurrence
  function automatic word_t taus_step(input word_t x, input int unsigned lsh,
                                      input int unsigned rsh, input int unsigned fsh,
                                      input word_t keep);
    word_t fb;
    fb = ((x << lsh) ^ x) >> rsh;
    return ((x & keep) << fsh) ^ fb;
  endfunction

  // Replace a seed that sits below the lane floor
  function automatic word_t seed_guard(input word_t s, input word_t floor_v);
    return (s < floor_v) ? DEFAULT_SEED : s;
  endfunction
endpackage

// File: rtl/tri_taus_lane.sv
module tri_taus_lane
  import tri_taus_pkg::*;
#(
  parameter int unsigned LSH   = 13,
  parameter int unsigned RSH   = 19,
  parameter int unsigned FSH   = 12,
  parameter int unsigned FLOOR = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  logic  adv,
  input  word_t seed,
  output word_t cur,
  output word_t nxt
);
  localparam word_t FLOOR_W = word_t'(FLOOR);
  localparam word_t KEEP    = ~(FLOOR_W - word_t'(1));

  assign nxt = taus_step(cur, LSH, RSH, FSH, KEEP);

  always_ff @(posedge clk) begin
    if (rst)       cur <= DEFAULT_SEED;
    else if (load) cur <= seed_guard(seed, FLOOR_W);
    else if (adv)  cur <= nxt;
  end
endmodule

// File: rtl/tri_taus_mix.sv
module tri_taus_mix
  import tri_taus_pkg::*;
#(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0][W-1:0] words,
  output word_t               folded
);
  always_comb begin
    folded = '0;
    for (int i = 0; i < int'(N); i++) folded = folded ^ words[i];
  end
endmodule

// File: rtl/tri_taus_gen.sv
module tri_taus_gen
  import tri_taus_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        seed_load,
  input  logic [31:0] seed_a,
  input  logic [31:0] seed_b,
  input  logic [31:0] seed_c,
  input  logic        advance,
  output logic [31:0] rand_out,
  output logic        rand_valid
);
  logic [NCOMP-1:0][W-1:0] seed_vec;
  logic [NCOMP-1:0][W-1:0] cur_vec;
  logic [NCOMP-1:0][W-1:0] nxt_vec;
  word_t                   mixed;

  // Named events and state for the checker
  logic  step_fire;
  word_t st_a, st_b, st_c;

  assign seed_vec  = {seed_c, seed_b, seed_a};
  assign step_fire = advance & ~seed_load;
  assign st_a      = cur_vec[0];
  assign st_b      = cur_vec[1];
  assign st_c      = cur_vec[2];

  for (genvar g = 0; g < int'(NCOMP); g++) begin : g_lane
    tri_taus_lane #(
      .LSH  (LSH_TAB[g]),
      .RSH  (RSH_TAB[g]),
      .FSH  (FSH_TAB[g]),
      .FLOOR(FLOOR_TAB[g])
    ) u_lane (
      .clk (clk),
      .rst (rst),
      .load(seed_load),
      .adv (advance),
      .seed(seed_vec[g]),
      .cur (cur_vec[g]),
      .nxt (nxt_vec[g])
    );
  end

  tri_taus_mix #(.N(NCOMP)) u_mix (
    .words (nxt_vec),
    .folded(mixed)
  );

  always_ff @(posedge clk) begin
    if (rst || seed_load) begin
      rand_out   <= '0;
      rand_valid <= 1'b0;
    end else if (step_fire) begin
      rand_out   <= mixed;
      rand_valid <= 1'b1;
    end
  end
endmodule

// File: rtl/tri_taus_chk.sv
module tri_taus_chk
  import tri_taus_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        seed_load,
  input logic        advance,
  input logic [31:0] seed_a,
  input logic [31:0] seed_b,
  input logic [31:0] seed_c,
  input logic [31:0] st_a,
  input logic [31:0] st_b,
  input logic [31:0] st_c,
  input logic [31:0] rand_out,
  input logic        rand_valid
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (st_a == DEFAULT_SEED && st_b == DEFAULT_SEED && st_c == DEFAULT_SEED
             && !rand_valid && rand_out == 32'd0));

  // R5
  out_matches_state_chk: assert property (@(posedge clk) disable iff (rst)
    rand_valid |-> (rand_out == (st_a ^ st_b ^ st_c)));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!seed_load && !advance) |=> ($stable(st_a) && $stable(st_b) && $stable(st_c)
                                  && $stable(rand_out) && $stable(rand_valid)));

  // R8
  valid_after_step_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && !seed_load) |=> rand_valid);

  // R9
  seed_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (seed_load && seed_a >= 32'd2 && seed_b >= 32'd8 && seed_c >= 32'd16)
    |=> (st_a == $past(seed_a) && st_b == $past(seed_b) && st_c == $past(seed_c)));

  // R9
  seed_replace_chk: assert property (@(posedge clk) disable iff (rst)
    (seed_load && seed_a < 32'd2 && seed_b < 32'd8 && seed_c < 32'd16)
    |=> (st_a == DEFAULT_SEED && st_b == DEFAULT_SEED && st_c == DEFAULT_SEED));

  // R10
  load_clears_chk: assert property (@(posedge clk) disable iff (rst)
    seed_load |=> (!rand_valid && rand_out == 32'd0));
endmodule

bind tri_taus_gen tri_taus_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .seed_load (seed_load),
  .advance   (advance),
  .seed_a    (seed_a),
  .seed_b    (seed_b),
  .seed_c    (seed_c),
  .st_a      (st_a),
  .st_b      (st_b),
  .st_c      (st_c),
  .rand_out  (rand_out),
  .rand_valid(rand_valid)
);

// File: tb/tri_taus_gen_bench.sv
module tri_taus_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        seed_load = 1'b0;
  logic [31:0] seed_a = '0, seed_b = '0, seed_c = '0;
  logic        advance = 1'b0;
  logic [31:0] rand_out;
  logic        rand_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  tri_taus_gen u_tri_taus_gen (
    .clk(clk), .rst(rst), .seed_load(seed_load),
    .seed_a(seed_a), .seed_b(seed_b), .seed_c(seed_c),
    .advance(advance), .rand_out(rand_out), .rand_valid(rand_valid)
  );

  // Reference steps, written with bit slices
  function automatic logic [31:0] ref_a(input logic [31:0] x);
    logic [31:0] t;
    t = x ^ (x << 13);
    return {x[19:1], 13'b0} ^ (t >> 19);
  endfunction
  function automatic logic [31:0] ref_b(input logic [31:0] x);
    logic [31:0] t;
    t = x ^ (x << 2);
    return {x[27:3], 7'b0} ^ (t >> 25);
  endfunction
  function automatic logic [31:0] ref_c(input logic [31:0] x);
    logic [31:0] t;
    t = x ^ (x << 3);
    return {x[14:4], 21'b0} ^ (t >> 11);
  endfunction

  logic [31:0] ma, mb, mc;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                      input bit with_adv);
    @(negedge clk);
    seed_a = a; seed_b = b; seed_c = c;
    seed_load = 1'b1; advance = with_adv;
    @(negedge clk);
    seed_load = 1'b0; advance = 1'b0;
    ma = (a < 32'd2)  ? 32'd12345 : a;
    mb = (b < 32'd8)  ? 32'd12345 : b;
    mc = (c < 32'd16) ? 32'd12345 : c;
  endtask

  task automatic step_once();
    advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
    ma = ref_a(ma); mb = ref_b(mb); mc = ref_c(mc);
  endtask

  localparam int NVEC = 6;
  localparam logic [95:0] VEC [NVEC] = '{
    {32'd12345,      32'd12345,      32'd12345},
    {32'hDEADBEEF,   32'h0123_4567,  32'h89AB_CDEF},
    {32'd2,          32'd8,          32'd16},
    {32'd1,          32'd7,          32'd15},
    {32'd0,          32'd0,          32'd0},
    {32'hFFFF_FFFF,  32'hFFFF_FFFF,  32'hFFFF_FFFF}
  };

  initial begin
    logic [31:0] w0, w1, hold_w;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 out after reset", rand_out, 32'd0);
    check("R1 valid after reset", {31'd0, rand_valid}, 32'd1 - 32'd1);
    ma = 32'd12345; mb = 32'd12345; mc = 32'd12345;
    step_once();
    check("R1 first word from default seed", rand_out, ma ^ mb ^ mc);
    check("R8 valid after step", {31'd0, rand_valid}, 32'd1);

    // R7 hold while idle
    hold_w = rand_out;
    repeat (3) @(negedge clk);
    check("R7 output held", rand_out, hold_w);
    check("R7 valid held", {31'd0, rand_valid}, 32'd1);

    // Table walk: load, then run with advance held high
    for (int v = 0; v < NVEC; v++) begin
      load(VEC[v][95:64], VEC[v][63:32], VEC[v][31:0], 1'b0);
      check("R10 out cleared by load", rand_out, 32'd0);
      check("R8 valid cleared by load", {31'd0, rand_valid}, 32'd0);
      advance = 1'b1;
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        ma = ref_a(ma); mb = ref_b(mb); mc = ref_c(mc);
        check("R5 R6 R9 streamed word", rand_out, ma ^ mb ^ mc);
      end
      advance = 1'b0;
    end

    // R9 boundary: just-below seeds behave like the default seed
    load(32'd1, 32'd7, 32'd15, 1'b0);
    step_once();
    check("R9 below-floor replaced", rand_out,
          ref_a(32'd12345) ^ ref_b(32'd12345) ^ ref_c(32'd12345));
    load(32'd2, 32'd8, 32'd16, 1'b0);
    step_once();
    check("R9 at-floor kept", rand_out, ref_a(32'd2) ^ ref_b(32'd8) ^ ref_c(32'd16));

    // R2 R3 R4: single-lane differences isolate each recurrence
    load(32'h1357_9BDF, 32'h2468_ACE0, 32'h0F0F_F0F0, 1'b0); step_once(); w0 = rand_out;
    load(32'h7777_0001, 32'h2468_ACE0, 32'h0F0F_F0F0, 1'b0); step_once(); w1 = rand_out;
    check("R2 lane A step", w0 ^ w1, ref_a(32'h1357_9BDF) ^ ref_a(32'h7777_0001));
    load(32'h1357_9BDF, 32'hCAFE_0008, 32'h0F0F_F0F0, 1'b0); step_once(); w1 = rand_out;
    check("R3 lane B step", w0 ^ w1, ref_b(32'h2468_ACE0) ^ ref_b(32'hCAFE_0008));
    load(32'h1357_9BDF, 32'h2468_ACE0, 32'h8000_0010, 1'b0); step_once(); w1 = rand_out;
    check("R4 lane C step", w0 ^ w1, ref_c(32'h0F0F_F0F0) ^ ref_c(32'h8000_0010));

    // R10 load wins over advance
    load(32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'h3C3C_3C3C, 1'b1);
    check("R10 valid low with load+advance", {31'd0, rand_valid}, 32'd0);
    check("R10 out zero with load+advance", rand_out, 32'd0);
    step_once();
    check("R10 lanes not stepped at load", rand_out, ma ^ mb ^ mc);

    // R1 reset mid-run
    @(negedge clk); rst = 1'b1; advance = 1'b1;
    @(negedge clk); rst = 1'b0; advance = 1'b0;
    check("R1 valid cleared by reset", {31'd0, rand_valid}, 32'd0);
    ma = 32'd12345; mb = 32'd12345; mc = 32'd12345;
    step_once();
    check("R1 reseeded default", rand_out, ma ^ mb ^ mc);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule